// File: doc/BRIEF.md
# Memory-Mapped Receive/Transmit Device Pair

This block puts two small peripherals behind one CPU register bus. The bus has an address, a write enable, write data and a combinational read data path. The receive side captures a byte whenever an external producer pulses a strobe. It raises a data-ready flag and holds its interrupt line high until software acknowledges the byte. The transmit side holds a word that software loads. Software then starts a send by setting a transmit-enable bit. The device offers the word to an external sink with a valid/ready handshake and clears the enable itself once the sink takes the word.

Status bits split into two kinds. Hardware sets the flags and software clears them: data-ready and overrun on the receive side. Software sets the transmit-enable bit and hardware clears it. Both interrupt lines are plain levels derived from these flags, so a handler that acknowledges its flag also drops its request. A read never changes state.

Top module: `mmio_dev_pair`

## Requirements
- R1: After reset, receive status (0xA0) and receive data (0xA1) read 0 and transmit data (0xB1) reads 0. Transmit status (0xB0) reads 0x0001, with bit 0 ready-to-send = 1 and bit 1 transmit-enable = 0. irq_in is 0, irq_out is 1 and tx_valid is 0.
- R2: A cycle with rx_strobe high stores rx_byte into receive data (0xA1, low 8 bits). From the next cycle, bit 0 (data-ready) of 0xA0 reads 1 and irq_in is 1. irq_in always equals data-ready.
- R3: A strobe that arrives while data-ready is already 1 overwrites receive data with the new byte and sets bit 1 (overrun) of 0xA0.
- R4: A write to 0xA0 clears data-ready when write-data bit 0 is 0, and clears overrun when write-data bit 1 is 0. A write bit of 1 leaves its flag unchanged. Neither reads nor the passage of time clear these flags.
- R5: If a strobe and a clearing write to 0xA0 fall in the same cycle, the strobe wins. Data-ready stays 1, and overrun is set if data-ready was already 1.
- R6: A write to 0xB1 loads the transmit word while transmit-enable is 0. While transmit-enable is 1, such writes are ignored and tx_word holds steady.
- R7: A write to 0xB0 with bit 1 = 1 while idle sets transmit-enable from the next cycle. At the same point ready-to-send falls to 0, tx_valid rises, tx_word presents the stored word and irq_out falls. Writing bit 1 = 0, or writing bit 0, has no effect.
- R8: While tx_valid is high and tx_ready is low, tx_valid and tx_word hold. In the cycle after tx_valid and tx_ready are both high, transmit-enable is 0, ready-to-send is 1, tx_valid is 0 and irq_out is 1. irq_out equals ready-to-send AND NOT transmit-enable.
- R9: A read of an unmapped address returns 0, and writes to 0xA1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| rx_strobe | input | 1 | One-cycle pulse: rx_byte is valid |
| rx_byte | input | RX_W | Incoming byte |
| irq_in | output | 1 | Receive interrupt level |
| tx_valid | output | 1 | Transmit word offered to the sink |
| tx_ready | input | 1 | Sink accepts the word |
| tx_word | output | DATA_W | Word being transmitted |
| irq_out | output | 1 | Transmit interrupt level |

## Verification
The bench uses the default parameters: an 8-bit address, a 16-bit bus and transmit word, an 8-bit receive byte and the four register offsets 0xA0, 0xA1, 0xB0 and 0xB1. With these values every register and an unmapped address can be reached. The full 16-bit transmit path is exercised, as are the zero-extended 8-bit receive path and the status bytes. A receive overrun, a strobe that collides with a clearing write, and writes landing during a stalled transmission can all be driven from the bus and strobe ports.

// File: rtl/mmio_dev_pair.sv
module mmio_dev_pair #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int RX_W = 8,
  parameter logic [ADDR_W-1:0] RX_STAT_ADDR = 8'hA0,
  parameter logic [ADDR_W-1:0] RX_DATA_ADDR = 8'hA1,
  parameter logic [ADDR_W-1:0] TX_STAT_ADDR = 8'hB0,
  parameter logic [ADDR_W-1:0] TX_DATA_ADDR = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_strobe,
  input  logic [RX_W-1:0]   rx_byte,
  output logic              irq_in,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_word,
  output logic              irq_out
);

  localparam int PAD_RX = DATA_W - RX_W;
  localparam int PAD_ST = DATA_W - 2;

  logic [RX_W-1:0]   rx_q;
  logic              rx_rdy, rx_ovr;
  logic [DATA_W-1:0] tx_q;
  logic              tx_en;
  logic              rts;

  wire wr_rx_stat = bus_we && (bus_addr == RX_STAT_ADDR);
  wire wr_tx_stat = bus_we && (bus_addr == TX_STAT_ADDR);
  wire wr_tx_data = bus_we && (bus_addr == TX_DATA_ADDR);
  wire tx_fire    = tx_en && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q   <= '0;
      rx_rdy <= 1'b0;
      rx_ovr <= 1'b0;
    end else if (rx_strobe) begin
      rx_q   <= rx_byte;
      rx_rdy <= 1'b1;
      if (rx_rdy) rx_ovr <= 1'b1;
    end else if (wr_rx_stat) begin
      if (!bus_wdata[0]) rx_rdy <= 1'b0;
      if (!bus_wdata[1]) rx_ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q  <= '0;
      tx_en <= 1'b0;
    end else if (tx_en) begin
      if (tx_ready) tx_en <= 1'b0;
    end else begin
      if (wr_tx_data) tx_q <= bus_wdata;
      if (wr_tx_stat && bus_wdata[1]) tx_en <= 1'b1;
    end
  end

  assign rts      = !tx_en;
  assign irq_in   = rx_rdy;
  assign irq_out  = rts && !tx_en;
  assign tx_valid = tx_en;
  assign tx_word  = tx_q;

  always_comb begin
    if (bus_addr == RX_STAT_ADDR)      bus_rdata = {{PAD_ST{1'b0}}, rx_ovr, rx_rdy};
    else if (bus_addr == RX_DATA_ADDR) bus_rdata = {{PAD_RX{1'b0}}, rx_q};
    else if (bus_addr == TX_STAT_ADDR) bus_rdata = {{PAD_ST{1'b0}}, tx_en, rts};
    else if (bus_addr == TX_DATA_ADDR) bus_rdata = tx_q;
    else                               bus_rdata = '0;
  end

  p_rdy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> irq_in);

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && irq_in) |=> (bus_addr != RX_STAT_ADDR) || bus_rdata[1]);

  p_rdy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !(wr_rx_stat && !bus_wdata[0])) |=> irq_in);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_word));

  p_tx_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid && irq_out);

  p_tx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && wr_tx_stat && bus_wdata[1]) |=> tx_valid && !irq_out);

endmodule

// File: tb/mmio_dev_pair_test.sv
`timescale 1ns/1ps
module mmio_dev_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        irq_in, tx_valid, irq_out;
  logic        tx_ready = 1'b0;
  logic [15:0] tx_word;

  int checks = 0;
  int errors = 0;

  int    exp_kind[$];
  int    exp_val[$];
  string exp_tag[$];
  int    tx_exp[$];

  always #10 clk = ~clk;

  mmio_dev_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .irq_in(irq_in), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_word(tx_word), .irq_out(irq_out)
  );

  // kinds: 0 read data, 1 irq_in, 2 irq_out, 3 tx_valid
  always @(negedge clk) begin
    if (exp_kind.size() > 0) begin
      int k, v, a;
      string t;
      k = exp_kind.pop_front();
      v = exp_val.pop_front();
      t = exp_tag.pop_front();
      case (k)
        0:       a = int'(bus_rdata);
        1:       a = int'(irq_in);
        2:       a = int'(irq_out);
        default: a = int'(tx_valid);
      endcase
      checks++;
      if (a != v) begin
        errors++;
        $display("FAIL %s kind%0d: got %h expected %h", t, k, a, v);
      end
    end
    if (rst_n && tx_valid && tx_ready) begin
      checks++;
      if (tx_exp.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected handshake: got %h expected none", tx_word);
      end else begin
        int e;
        e = tx_exp.pop_front();
        if (int'(tx_word) != e) begin
          errors++;
          $display("FAIL R8 tx_word: got %h expected %h", tx_word, e);
        end
      end
    end
  end

  task automatic step(input logic [7:0] a, input logic we, input logic [15:0] d,
                      input logic stb, input logic [7:0] b, input logic rdy);
    @(posedge clk); #1;
    bus_addr = a; bus_we = we; bus_wdata = d;
    rx_strobe = stb; rx_byte = b; tx_ready = rdy;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(a, 1'b1, d, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic strobe(input logic [7:0] b);
    step(8'h00, 1'b0, 16'h0, 1'b1, b, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input int e, input string t);
    step(a, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
    exp_kind.push_back(0); exp_val.push_back(e); exp_tag.push_back(t);
  endtask

  task automatic sig(input int k, input int e, input string t);
    step(8'h00, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
    exp_kind.push_back(k); exp_val.push_back(e); exp_tag.push_back(t);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(8'hA0, 'h0000, "R1 rx status");
    rd(8'hA1, 'h0000, "R1 rx data");
    rd(8'hB0, 'h0001, "R1 tx status");
    rd(8'hB1, 'h0000, "R1 tx data");
    sig(1, 0, "R1 irq_in");
    sig(2, 1, "R1 irq_out");
    sig(3, 0, "R1 tx_valid");
    // R2 receive
    strobe(8'h3C);
    rd(8'hA1, 'h003C, "R2 rx data");
    rd(8'hA0, 'h0001, "R2 data-ready");
    sig(1, 1, "R2 irq_in");
    // R3 overrun
    strobe(8'h5A);
    rd(8'hA1, 'h005A, "R3 overwrite");
    rd(8'hA0, 'h0003, "R3 overrun");
    // R4 selective clear and persistence
    wr(8'hA0, 16'h0001);
    rd(8'hA0, 'h0001, "R4 clear overrun only");
    repeat (3) step(8'h00, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
    rd(8'hA0, 'h0001, "R4 ready persists");
    wr(8'hA0, 16'h0000);
    rd(8'hA0, 'h0000, "R4 cleared");
    sig(1, 0, "R4 irq_in low");
    // R5 strobe vs clear
    strobe(8'h77);
    step(8'hA0, 1'b1, 16'h0000, 1'b1, 8'h81, 1'b0);
    rd(8'hA0, 'h0003, "R5 strobe wins");
    rd(8'hA1, 'h0081, "R5 data");
    wr(8'hA0, 16'h0000);
    // R9 ignored writes and unmapped read
    wr(8'hA1, 16'h0055);
    rd(8'hA1, 'h0081, "R9 rx data write ignored");
    rd(8'h10, 'h0000, "R9 unmapped");
    // R7 bit1=0 write does nothing
    wr(8'hB0, 16'h0001);
    rd(8'hB0, 'h0001, "R7 no start");
    sig(3, 0, "R7 tx_valid idle");
    // R6/R7/R8 transmission with stall
    wr(8'hB1, 16'h1234);
    rd(8'hB1, 'h1234, "R6 load");
    wr(8'hB0, 16'h0002);
    rd(8'hB0, 'h0002, "R7 enable set");
    sig(3, 1, "R7 tx_valid");
    sig(2, 0, "R7 irq_out low");
    wr(8'hB1, 16'hFFFF);
    rd(8'hB1, 'h1234, "R6 busy write ignored");
    sig(3, 1, "R8 stall holds");
    tx_exp.push_back('h1234);
    step(8'h00, 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
    rd(8'hB0, 'h0001, "R8 done status");
    sig(2, 1, "R8 irq_out back");
    sig(3, 0, "R8 tx_valid low");
    // second word, immediate accept
    wr(8'hB1, 16'hBEEF);
    wr(8'hB0, 16'h0002);
    tx_exp.push_back('hBEEF);
    step(8'h00, 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
    rd(8'hB0, 'h0001, "R8 second done");
    step(8'h00, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    if (tx_exp.size() != 0) begin
      errors++;
      $display("FAIL R8 handshakes missing: got %0d left expected 0", tx_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule